// File: doc/BRIEF.md
# Mixed-Shape Dual-Port Block Memory

This block is an 18 Kb synchronous memory with two fully independent ports. Each port has its own clock, enable, write enable, synchronous output clear, address, write data, write parity, read data and read parity. A parameter gives each port its own shape: 16384x1, 8192x2, 4096x4, 2048x9, 1024x18 or 512x36. Because the shape is set per port, one port can store data in one shape while the other reads it back in another. The storage is one shared space: 16 Kb of data bits and a 2 Kb parity side space.

The 9, 18 and 36-bit shapes split each word into 8, 16 or 32 data bits and 1, 2 or 4 parity bits, carried on separate parity buses. The 1, 2 and 4-bit shapes have no parity, so they reach only the data bits. Further parameters select, for each port, the active clock edge (rising or falling) and the output behaviour on a write: write-first shows the new data, read-first shows the old contents.

Both ports register every input on their active edge and drive their outputs from registers. Address data, parity and address buses have the widest width on every port. Each port uses only the low bits that its shape needs.

Top module: `dpram_mixed`

## Requirements
- R1: A port of shape W uses address bits [AW-1:0] (AW = 14, 13, 12, 11, 10, 9 for W = 1, 2, 4, 9, 18, 36). It uses data bits [DW-1:0], where DW = W for narrow shapes and DW = 8·W/9 otherwise. It uses parity bits [PW-1:0], where PW = W/9 for wide shapes and 0 for narrow ones. Higher input bits are ignored, and higher output bits always read 0.
- R2: With enable high, write enable low and clear low, the output registers take the addressed word and its parity on the port's active edge.
- R3: With enable and write enable high, the write data (and, on a wide port, the write parity) is stored at the addressed word on the active edge.
- R4: On a write-first port, a write loads the output registers with the masked write data and parity on the same edge.
- R5: On a read-first port, a write loads the output registers with the word's previous contents on the same edge.
- R6: With enable low, nothing is stored and both output registers keep their value, whatever the other inputs do.
- R7: With enable and clear high, the data and parity outputs become 0 on the active edge. A write requested on that edge is still stored.
- R8: Word A of a port with data width DW covers linear data bits A·DW to A·DW+DW-1, least significant first. Parity bit k of a wide word A is linear parity bit A·PW+k. Narrow ports never change parity bits.
- R9: A port configured for the falling edge samples its inputs and updates its outputs only on falling clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkA | input | 1 | Port A clock |
| enA | input | 1 | Port A enable |
| weA | input | 1 | Port A write enable |
| rstA | input | 1 | Port A synchronous output clear |
| addrA | input | 14 | Port A word address |
| dinA | input | 32 | Port A write data |
| dinParA | input | 4 | Port A write parity |
| doutA | output | 32 | Port A read data |
| doutParA | output | 4 | Port A read parity |
| clkB | input | 1 | Port B clock |
| enB | input | 1 | Port B enable |
| weB | input | 1 | Port B write enable |
| rstB | input | 1 | Port B synchronous output clear |
| addrB | input | 14 | Port B word address |
| dinB | input | 32 | Port B write data |
| dinParB | input | 4 | Port B write parity |
| doutB | output | 32 | Port B read data |
| doutParB | output | 4 | Port B read parity |

## Verification
The assertions assume that each port's inputs are stable around that port's active edge. They also assume that the two ports never write the same word at the same instant, and they start checking a port's outputs only after that port has been enabled once. The bench drives every input just after a rising edge. It runs port A on the rising edge and port B on the falling edge of one clock, so the two ports never act at the same moment, even when their addresses overlap. This also gives a defined order for cross-port read-after-write cases. Unused high address and data bits are driven with random values throughout, so they are shown to have no effect.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

  localparam int WORDS   = 512;
  localparam int WORD_W  = $clog2(WORDS);
  localparam int LANE_W  = 32;
  localparam int PLANE_W = 4;
  localparam int ROW_W   = LANE_W + PLANE_W;
  localparam int ADDR_W  = 14;

  typedef struct packed {
    logic              rd;
    logic              wr;
    logic              clr;
    logic [WORD_W-1:0] word;
    logic [4:0]        dOff;
    logic [1:0]        pOff;
  } portStrobe_t;

  function automatic int dataW(int w);
    return (w >= 9) ? (w / 9) * 8 : w;
  endfunction

  function automatic int parW(int w);
    return (w >= 9) ? w / 9 : 0;
  endfunction

  function automatic int addrW(int w);
    return ADDR_W - $clog2(dataW(w));
  endfunction

  function automatic logic [LANE_W-1:0] laneMask(int dw);
    return LANE_W'((64'd1 << dw) - 64'd1);
  endfunction

  function automatic logic [PLANE_W-1:0] planeMask(int pw);
    return PLANE_W'((8'd1 << pw) - 8'd1);
  endfunction

  // merge one port-sized slice into a 36-bit row
  function automatic logic [ROW_W-1:0] placeSlice(
      logic [ROW_W-1:0] cur, logic [LANE_W-1:0] din, logic [PLANE_W-1:0] par,
      int dw, int pw, logic [4:0] dOff, logic [1:0] pOff);
    logic [ROW_W-1:0] mask;
    logic [ROW_W-1:0] val;
    mask = {planeMask(pw) << pOff, laneMask(dw) << dOff};
    val  = {(par & planeMask(pw)) << pOff, (din & laneMask(dw)) << dOff};
    return (cur & ~mask) | val;
  endfunction

  // extract one port-sized slice, zero-extended
  function automatic logic [ROW_W-1:0] pickSlice(
      logic [ROW_W-1:0] cur, int dw, int pw, logic [4:0] dOff, logic [1:0] pOff);
    logic [LANE_W-1:0]  d;
    logic [PLANE_W-1:0] p;
    d = (cur[LANE_W-1:0] >> dOff) & laneMask(dw);
    p = (cur[ROW_W-1:LANE_W] >> pOff) & planeMask(pw);
    return {p, d};
  endfunction

endpackage

// File: rtl/dpram_port_ctrl.sv
module dpram_port_ctrl
  import dpram_pkg::*;
#(
  parameter int WIDTH = 36
) (
  input  logic              en,
  input  logic              we,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  output portStrobe_t       strb
);

  localparam int DW  = dataW(WIDTH);
  localparam int PW  = parW(WIDTH);
  localparam int AW  = addrW(WIDTH);
  localparam int DSH = $clog2(DW);

  logic [AW-1:0]     addrUsed;
  logic [ADDR_W-1:0] bitAddr;
  logic [1:0]        parOff;

  assign addrUsed = addr[AW-1:0];
  assign bitAddr  = ADDR_W'(addrUsed) << DSH;

  generate
    if (AW < ADDR_W) begin : g_spare
      logic unusedAddrHi;
      assign unusedAddrHi = ^addr[ADDR_W-1:AW];
    end
    if (PW == 1) begin : g_p1
      assign parOff = addrUsed[1:0];
    end else if (PW == 2) begin : g_p2
      assign parOff = {addrUsed[0], 1'b0};
    end else begin : g_p0
      assign parOff = 2'b00;
    end
  endgenerate

  always_comb begin
    strb.rd   = en;
    strb.wr   = en & we;
    strb.clr  = en & rst;
    strb.word = bitAddr[ADDR_W-1:5];
    strb.dOff = bitAddr[4:0];
    strb.pOff = parOff;
  end

endmodule

// File: rtl/dpram_datapath.sv
module dpram_datapath
  import dpram_pkg::*;
#(
  parameter int WIDTH_A       = 36,
  parameter int WIDTH_B       = 4,
  parameter bit WRITE_FIRST_A = 1'b1,
  parameter bit WRITE_FIRST_B = 1'b0
) (
  input  logic               clkA,
  input  portStrobe_t        strbA,
  input  logic [LANE_W-1:0]  dinA,
  input  logic [PLANE_W-1:0] dinParA,
  output logic [LANE_W-1:0]  doutA,
  output logic [PLANE_W-1:0] doutParA,
  input  logic               clkB,
  input  portStrobe_t        strbB,
  input  logic [LANE_W-1:0]  dinB,
  input  logic [PLANE_W-1:0] dinParB,
  output logic [LANE_W-1:0]  doutB,
  output logic [PLANE_W-1:0] doutParB
);

  localparam int DWA = dataW(WIDTH_A);
  localparam int PWA = parW(WIDTH_A);
  localparam int DWB = dataW(WIDTH_B);
  localparam int PWB = parW(WIDTH_B);
  localparam logic [LANE_W-1:0]  DMA = laneMask(DWA);
  localparam logic [PLANE_W-1:0] PMA = planeMask(PWA);
  localparam logic [LANE_W-1:0]  DMB = laneMask(DWB);
  localparam logic [PLANE_W-1:0] PMB = planeMask(PWB);

  // row value = bankA ^ bankB; each bank has a single writer clock
  logic [ROW_W-1:0] bankA [WORDS];
  logic [ROW_W-1:0] bankB [WORDS];

  logic [ROW_W-1:0] curA, curB, nextA, nextB, oldA, oldB;

  assign curA  = bankA[strbA.word] ^ bankB[strbA.word];
  assign curB  = bankA[strbB.word] ^ bankB[strbB.word];
  assign nextA = placeSlice(curA, dinA, dinParA, DWA, PWA, strbA.dOff, strbA.pOff);
  assign nextB = placeSlice(curB, dinB, dinParB, DWB, PWB, strbB.dOff, strbB.pOff);
  assign oldA  = pickSlice(curA, DWA, PWA, strbA.dOff, strbA.pOff);
  assign oldB  = pickSlice(curB, DWB, PWB, strbB.dOff, strbB.pOff);

  always_ff @(posedge clkA) begin
    if (strbA.wr) bankA[strbA.word] <= nextA ^ bankB[strbA.word];
    if (strbA.clr) begin
      doutA    <= '0;
      doutParA <= '0;
    end else if (strbA.rd) begin
      if (strbA.wr && WRITE_FIRST_A) begin
        doutA    <= dinA & DMA;
        doutParA <= dinParA & PMA;
      end else begin
        {doutParA, doutA} <= oldA;
      end
    end
  end

  always_ff @(posedge clkB) begin
    if (strbB.wr) bankB[strbB.word] <= nextB ^ bankA[strbB.word];
    if (strbB.clr) begin
      doutB    <= '0;
      doutParB <= '0;
    end else if (strbB.rd) begin
      if (strbB.wr && WRITE_FIRST_B) begin
        doutB    <= dinB & DMB;
        doutParB <= dinParB & PMB;
      end else begin
        {doutParB, doutB} <= oldB;
      end
    end
  end

endmodule

// File: rtl/dpram_mixed.sv
module dpram_mixed
  import dpram_pkg::*;
#(
  parameter int WIDTH_A       = 36,
  parameter int WIDTH_B       = 4,
  parameter bit WRITE_FIRST_A = 1'b1,
  parameter bit WRITE_FIRST_B = 1'b0,
  parameter bit FALLING_A     = 1'b0,
  parameter bit FALLING_B     = 1'b1
) (
  input  logic        clkA,
  input  logic        enA,
  input  logic        weA,
  input  logic        rstA,
  input  logic [13:0] addrA,
  input  logic [31:0] dinA,
  input  logic [3:0]  dinParA,
  output logic [31:0] doutA,
  output logic [3:0]  doutParA,
  input  logic        clkB,
  input  logic        enB,
  input  logic        weB,
  input  logic        rstB,
  input  logic [13:0] addrB,
  input  logic [31:0] dinB,
  input  logic [3:0]  dinParB,
  output logic [31:0] doutB,
  output logic [3:0]  doutParB
);

  logic        edgeClkA, edgeClkB;
  portStrobe_t strbA, strbB;

  assign edgeClkA = clkA ^ FALLING_A;
  assign edgeClkB = clkB ^ FALLING_B;

  dpram_port_ctrl #(.WIDTH(WIDTH_A)) u_ctrlA (
    .en(enA), .we(weA), .rst(rstA), .addr(addrA), .strb(strbA)
  );

  dpram_port_ctrl #(.WIDTH(WIDTH_B)) u_ctrlB (
    .en(enB), .we(weB), .rst(rstB), .addr(addrB), .strb(strbB)
  );

  dpram_datapath #(
    .WIDTH_A(WIDTH_A), .WIDTH_B(WIDTH_B),
    .WRITE_FIRST_A(WRITE_FIRST_A), .WRITE_FIRST_B(WRITE_FIRST_B)
  ) u_data (
    .clkA(edgeClkA), .strbA(strbA), .dinA(dinA), .dinParA(dinParA),
    .doutA(doutA), .doutParA(doutParA),
    .clkB(edgeClkB), .strbB(strbB), .dinB(dinB), .dinParB(dinParB),
    .doutB(doutB), .doutParB(doutParB)
  );

endmodule

// File: rtl/dpram_mixed_checker.sv
module dpram_mixed_checker
  import dpram_pkg::*;
#(
  parameter int WIDTH_A       = 36,
  parameter int WIDTH_B       = 4,
  parameter bit WRITE_FIRST_A = 1'b1,
  parameter bit WRITE_FIRST_B = 1'b0,
  parameter bit FALLING_A     = 1'b0,
  parameter bit FALLING_B     = 1'b1
) (
  input logic        clkA,
  input logic        enA,
  input logic        weA,
  input logic        rstA,
  input logic [31:0] dinA,
  input logic [3:0]  dinParA,
  input logic [31:0] doutA,
  input logic [3:0]  doutParA,
  input logic        clkB,
  input logic        enB,
  input logic        weB,
  input logic        rstB,
  input logic [31:0] dinB,
  input logic [3:0]  dinParB,
  input logic [31:0] doutB,
  input logic [3:0]  doutParB
);

  localparam logic [31:0] DMA = laneMask(dataW(WIDTH_A));
  localparam logic [3:0]  PMA = planeMask(parW(WIDTH_A));
  localparam logic [31:0] DMB = laneMask(dataW(WIDTH_B));
  localparam logic [3:0]  PMB = planeMask(parW(WIDTH_B));

  logic effA, effB;
  logic armA = 1'b0;
  logic armB = 1'b0;

  assign effA = clkA ^ FALLING_A;
  assign effB = clkB ^ FALLING_B;

  always_ff @(posedge effA) if (enA) armA <= 1'b1;
  always_ff @(posedge effB) if (enB) armB <= 1'b1;

  assert_clear_a_R7: assert property (@(posedge effA) disable iff (!armA)
    enA && rstA |=> doutA == '0 && doutParA == '0);
  assert_clear_b_R7: assert property (@(posedge effB) disable iff (!armB)
    enB && rstB |=> doutB == '0 && doutParB == '0);

  assert_hold_a_R6: assert property (@(posedge effA) disable iff (!armA)
    !enA |=> $stable(doutA) && $stable(doutParA));
  assert_hold_b_R6: assert property (@(posedge effB) disable iff (!armB)
    !enB |=> $stable(doutB) && $stable(doutParB));

  assert_width_a_R1: assert property (@(posedge effA) disable iff (!armA)
    enA |=> (doutA & ~DMA) == '0 && (doutParA & ~PMA) == '0);
  assert_width_b_R1: assert property (@(posedge effB) disable iff (!armB)
    enB |=> (doutB & ~DMB) == '0 && (doutParB & ~PMB) == '0);

  generate
    if (WRITE_FIRST_A) begin : g_wfA
      assert_wfirst_a_R4: assert property (@(posedge effA) disable iff (!armA)
        enA && weA && !rstA |=>
          doutA == ($past(dinA) & DMA) && doutParA == ($past(dinParA) & PMA));
    end
    if (WRITE_FIRST_B) begin : g_wfB
      assert_wfirst_b_R4: assert property (@(posedge effB) disable iff (!armB)
        enB && weB && !rstB |=>
          doutB == ($past(dinB) & DMB) && doutParB == ($past(dinParB) & PMB));
    end
  endgenerate

endmodule

bind dpram_mixed dpram_mixed_checker #(
  .WIDTH_A(WIDTH_A), .WIDTH_B(WIDTH_B),
  .WRITE_FIRST_A(WRITE_FIRST_A), .WRITE_FIRST_B(WRITE_FIRST_B),
  .FALLING_A(FALLING_A), .FALLING_B(FALLING_B)
) u_chk (
  .clkA(clkA), .enA(enA), .weA(weA), .rstA(rstA), .dinA(dinA), .dinParA(dinParA),
  .doutA(doutA), .doutParA(doutParA),
  .clkB(clkB), .enB(enB), .weB(weB), .rstB(rstB), .dinB(dinB), .dinParB(dinParB),
  .doutB(doutB), .doutParB(doutParB)
);

// File: tb/dpram_mixed_test.sv
`timescale 1ns/1ps
module dpram_mixed_test;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        enA = 0, weA = 0, rstA = 0, enB = 0, weB = 0, rstB = 0;
  logic [13:0] addrA = '0, addrB = '0;
  logic [31:0] dinA = '0, dinB = '0, doutA, doutB;
  logic [3:0]  dinParA = '0, dinParB = '0, doutParA, doutParB;

  dpram_mixed #(
    .WIDTH_A(36), .WIDTH_B(4), .WRITE_FIRST_A(1'b1), .WRITE_FIRST_B(1'b0),
    .FALLING_A(1'b0), .FALLING_B(1'b1)
  ) uut (
    .clkA(clk), .enA(enA), .weA(weA), .rstA(rstA), .addrA(addrA), .dinA(dinA),
    .dinParA(dinParA), .doutA(doutA), .doutParA(doutParA),
    .clkB(clk), .enB(enB), .weB(weB), .rstB(rstB), .addrB(addrB), .dinB(dinB),
    .dinParB(dinParB), .doutB(doutB), .doutParB(doutParB)
  );

  // behavioural model: linear bit spaces
  bit [16383:0] mD;
  bit [2047:0]  mP;
  bit [31:0] expDA, expDB;
  bit [3:0]  expPA;
  bit knownA = 0, knownB = 0;
  int checks = 0, errors = 0;

  task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
    end
  endtask

  task automatic compareAll(string tag);
    if (knownA) begin
      chk(tag, "doutA", doutA, expDA);
      chk(tag, "doutParA", {28'b0, doutParA}, {28'b0, expPA});
    end
    if (knownB) begin
      chk(tag, "doutB", doutB, expDB);
      chk(tag, "doutParB", {28'b0, doutParB}, 32'b0);  // narrow: R1
    end
  endtask

  task automatic modelA();
    int a;
    bit [35:0] old;
    if (enA) begin
      a = int'(addrA[8:0]);
      old = {mP[a*4 +: 4], mD[a*32 +: 32]};
      knownA = 1;
      if (rstA) {expPA, expDA} = '0;
      else if (weA) {expPA, expDA} = {dinParA, dinA};   // write-first
      else {expPA, expDA} = old;
      if (weA) begin
        mD[a*32 +: 32] = dinA;
        mP[a*4 +: 4] = dinParA;
      end
    end
  endtask

  task automatic modelB();
    int a;
    bit [3:0] old;
    if (enB) begin
      a = int'(addrB[11:0]);
      old = mD[a*4 +: 4];
      knownB = 1;
      if (rstB) expDB = '0;
      else expDB = {28'b0, old};                          // read-first or plain read
      if (weB) mD[a*4 +: 4] = dinB[3:0];
    end
  endtask

  // port B acts on the falling edge, port A on the rising edge (R9)
  task automatic step(string tag);
    @(negedge clk);
    modelB();
    #1 compareAll(tag);
    @(posedge clk);
    modelA();
    #1 compareAll(tag);
  endtask

  task automatic setA(bit en, bit we, bit rs, int word, bit [31:0] d, bit [3:0] p);
    enA = en; weA = we; rstA = rs;
    addrA = {5'($urandom), 9'(word)};  // upper bits are noise (R1)
    dinA = d; dinParA = p;
  endtask

  task automatic setB(bit en, bit we, bit rs, int nib, bit [3:0] d);
    enB = en; weB = we; rstB = rs;
    addrB = {2'($urandom), 12'(nib)};
    dinB = {28'($urandom), d};         // upper data bits are noise (R1)
    dinParB = 4'($urandom);
  endtask

  function automatic bit [31:0] pat(int a);
    return (32'(a) * 32'h9E3779B1) ^ 32'hA5C3_0F1E;
  endfunction

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R7: clear both ports, reset state of outputs
    setA(1, 0, 1, 0, 32'hFFFF_FFFF, 4'hF);
    setB(1, 0, 1, 0, 4'hF);
    step("R7");

    // R3/R4: fill every word through the wide write-first port
    for (int a = 0; a < 512; a++) begin
      setA(1, 1, 0, a, pat(a), 4'(a ^ (a >> 4)));
      setB(0, 1, 0, $urandom, 4'($urandom));   // disabled B write (R6)
      step("R4");
    end

    // R2: wide reads
    for (int i = 0; i < 24; i++) begin
      setA(1, 0, 0, $urandom, $urandom, 4'($urandom));
      setB(0, 0, 0, 0, 0);
      step("R2");
    end

    // R8: narrow reads of data written wide
    for (int i = 0; i < 48; i++) begin
      setA(0, 1, 0, $urandom, $urandom, 4'($urandom));
      setB(1, 0, 0, $urandom, 4'($urandom));
      step("R8");
    end

    // R9: B reads a nibble between A writes to the same word
    for (int i = 0; i < 12; i++) begin
      automatic int w = int'($urandom % 512);
      setB(1, 0, 0, w * 8 + int'($urandom % 8), 4'($urandom));
      setA(1, 1, 0, w, $urandom, 4'($urandom));
      step("R9");
      step("R9");
    end

    // R5: narrow read-first writes, then wide readback
    for (int i = 0; i < 40; i++) begin
      automatic int n = int'($urandom % 4096);
      setA(0, 0, 0, 0, 0, 0);
      setB(1, 1, 0, n, 4'($urandom));
      step("R5");
      setB(0, 0, 0, 0, 0);
      setA(1, 0, 0, n / 8, $urandom, 4'($urandom));
      step("R8");                                // parity untouched by B
    end

    // R7: write during clear is still stored
    for (int i = 0; i < 8; i++) begin
      automatic int w = int'($urandom % 512);
      setA(1, 1, 1, w, $urandom, 4'($urandom));
      setB(1, 1, 1, w * 8 + 3, 4'($urandom));
      step("R7");
      setA(1, 0, 0, w, 0, 0);
      setB(1, 0, 0, w * 8 + 3, 0);
      step("R7");
    end

    // R6: disabled writes change nothing
    for (int i = 0; i < 16; i++) begin
      automatic int w = int'($urandom % 512);
      setA(0, 1, 0, w, $urandom, 4'($urandom));
      setB(0, 1, 1, w * 8, 4'($urandom));
      step("R6");
      setA(1, 0, 0, w, 0, 0);
      setB(1, 0, 0, w * 8, 0);
      step("R6");
    end

    // R3: random mixed traffic on both ports
    for (int i = 0; i < 400; i++) begin
      setA($urandom % 4 != 0, $urandom % 2 == 0, $urandom % 8 == 0,
           int'($urandom % 512), $urandom, 4'($urandom));
      setB($urandom % 4 != 0, $urandom % 2 == 0, $urandom % 8 == 0,
           int'($urandom % 4096), 4'($urandom));
      step("R3");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule